// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each data beat of a four-beat burst access to a synchronous memory array. A burst starts when the controller presents an external address with the advance/load control low. After that, each cycle with the control high steps an internal two-bit beat counter. The counter changes only the two low address bits, so a burst always stays inside the aligned group of four words it started in.

A run-time order input chooses how the low bits are formed. In linear order the loaded low bits are counted upward, modulo four. In interleaved order they are XORed with the beat count. A suspend input freezes the whole block. A load command issued while the device is not selected ends any burst in progress and leaves the address output where it was. An advance command that arrives while no burst is active changes nothing.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, beatAddr is 0 and burstActive is 0.
- R2: On an edge with suspend=0, advance=0 and selected=1, the base address takes the value of extAddr and the beat count goes to 0. After that edge beatAddr equals extAddr and burstActive is 1. This also happens when a burst is already active, in which case the old burst is replaced.
- R3: With interleave=0, the two low bits of beatAddr equal (L + k) mod 4, where L is the loaded low bits and k is the number of advances taken since the load. An advance (advance=1) during an active burst is taken whatever the value of selected.
- R4: With interleave=1, the two low bits of beatAddr equal L XOR k.
- R5: The beat count wraps modulo 4, so the fifth beat gives the same address as the first. Bits above bit 1 never change during a burst.
- R6: On an edge with suspend=1, every other input is ignored, and beatAddr and burstActive keep their values.
- R7: On an edge with suspend=0, advance=0 and selected=0, burstActive goes to 0 and beatAddr keeps its value.
- R8: An advance while burstActive=0 is ignored: beatAddr and burstActive stay unchanged.
- R9: The interleave input may change in the middle of a burst. beatAddr then follows the new order for the current beat count, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| suspend | input | 1 | 1 = freeze the block and ignore other inputs |
| advance | input | 1 | 1 = step the beat counter, 0 = load a new address |
| selected | input | 1 | 1 = device selected; sampled only on load cycles |
| interleave | input | 1 | Beat order select: 0 = linear, 1 = interleaved |
| extAddr | input | ADDR_W (17) | External word address presented on a load |
| beatAddr | output | ADDR_W (17) | Array word address for the current beat |
| burstActive | output | 1 | 1 while a loaded burst can be advanced |

## Verification
The bench runs full bursts past the fourth beat, in both orders and from non-zero starting low bits. A counter that carried into bit 2, or an order mix-up that added where it should XOR, would then show a wrong address on beats two to five. Suspend cycles carry load and advance values that would otherwise change state, so a block that ignores the suspend would be seen to move. The bench issues advances after a deselecting load and straight after reset; a design that lets such an advance through would step an address that should stay frozen. It also switches the order mid-burst and reloads during an active burst, which catches stale beat counts and a mode input that was latched instead of read live.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes from the control to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;   // capture a new base address, clear beat count
    logic stop;   // end the active burst
    logic step;   // advance the beat count
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        suspend,
  input  logic        advance,
  input  logic        selected,
  output seqStrobes_t strobes,
  output logic        burstActive
);

  always_comb begin
    strobes = '0;
    if (!suspend) begin
      if (!advance) begin
        if (selected) strobes.load = 1'b1;
        else          strobes.stop = 1'b1;
      end else if (burstActive) begin
        strobes.step = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             burstActive <= 1'b0;
    else if (strobes.load) burstActive <= 1'b1;
    else if (strobes.stop) burstActive <= 1'b0;
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && !advance && selected) |=> burstActive);
  p_deselect_stops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && !advance && !selected) |=> !burstActive);
  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> $stable(burstActive));
  p_idle_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !burstActive) |-> !strobes.step);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              suspend,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] beatAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strobes.load) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (strobes.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (interleave) lowBits = baseAddr[BEAT_W-1:0] ^ beatCnt;
    else            lowBits = baseAddr[BEAT_W-1:0] + beatCnt;
  end

  assign beatAddr = {baseAddr[ADDR_W-1:BEAT_W], lowBits};

  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (baseAddr == $past(extAddr)) && (beatCnt == '0));
  p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (beatCnt == BEAT_W'($past(beatCnt) + 1'b1))
                     && $stable(baseAddr));
  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(beatAddr[ADDR_W-1:BEAT_W]));
  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> $stable(baseAddr) && $stable(beatCnt));
  p_no_step_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(beatCnt) && $stable(baseAddr));

  initial begin
    assert (UPPER_W > 0) else $error("p_width_r5: ADDR_W must exceed BEAT_W");
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suspend,
  input  logic              advance,
  input  logic              selected,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              burstActive
);

  seqStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .suspend     (suspend),
    .advance     (advance),
    .selected    (selected),
    .strobes     (strobes),
    .burstActive (burstActive)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .suspend    (suspend),
    .interleave (interleave),
    .extAddr    (extAddr),
    .beatAddr   (beatAddr)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $fell(rstN) |=> (beatAddr == '0) && !burstActive);

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suspend = 1'b0, advance = 1'b1, selected = 1'b0, interleave = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] beatAddr;
  logic burstActive;

  always #10 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rstN(rstN), .suspend(suspend), .advance(advance),
    .selected(selected), .interleave(interleave), .extAddr(extAddr),
    .beatAddr(beatAddr), .burstActive(burstActive)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          act;
    string         tag;
  } expItem_t;

  expItem_t sbq[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = '0;
  logic          mAct = 1'b0;

  function automatic logic [AW-1:0] expAddr(input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    return {mBase[AW-1:2], lo};
  endfunction

  task automatic cyc(input logic sus, input logic adv, input logic sel,
                     input logic ilv, input logic [AW-1:0] a, input string tag);
    expItem_t it;
    @(negedge clk);
    suspend = sus; advance = adv; selected = sel; interleave = ilv; extAddr = a;
    if (!sus) begin
      if (!adv) begin
        if (sel) begin mBase = a; mCnt = 2'd0; mAct = 1'b1; end
        else mAct = 1'b0;
      end else if (mAct) begin
        mCnt = mCnt + 2'd1;
      end
    end
    it.addr = expAddr(ilv); it.act = mAct; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: one item per clock edge, sampled after the edge
  always @(posedge clk) begin
    #3;
    if (sbq.size() > 0) begin
      expItem_t e;
      e = sbq.pop_front();
      total++;
      if (beatAddr !== e.addr || burstActive !== e.act) begin
        bad++;
        $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                 e.tag, beatAddr, burstActive, e.addr, e.act);
      end
    end
  end

  task automatic direct(input string tag, input logic [AW-1:0] a, input logic act);
    total++;
    if (beatAddr !== a || burstActive !== act) begin
      bad++;
      $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
               tag, beatAddr, burstActive, a, act);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    direct("R1 reset", '0, 1'b0);

    // R8: advance with no burst since reset
    cyc(0, 1, 1, 0, 17'h1ABCD, "R8 idle advance");
    cyc(0, 1, 0, 1, 17'h00007, "R8 idle advance");

    // R2/R3/R5: linear burst from low bits 01, run past the fourth beat
    cyc(0, 0, 1, 0, 17'h12345, "R2 load");
    cyc(0, 1, 1, 0, 17'h0, "R3 linear beat1");
    cyc(0, 1, 0, 0, 17'h0, "R3 linear beat2 unselected");
    cyc(0, 1, 1, 0, 17'h0, "R3 linear beat3");
    cyc(0, 1, 1, 0, 17'h0, "R5 wrap to first beat");

    // R6: suspend with loads, deselects and advances presented
    cyc(1, 0, 1, 0, 17'h0AAAA, "R6 suspend load");
    cyc(1, 0, 0, 0, 17'h0, "R6 suspend deselect");
    cyc(1, 1, 1, 0, 17'h0, "R6 suspend advance");
    cyc(0, 1, 1, 0, 17'h0, "R3 resume beat1");

    // R7 then R8: deselect ends burst, later advances ignored
    cyc(0, 0, 0, 0, 17'h15555, "R7 deselect stop");
    cyc(0, 1, 1, 0, 17'h0, "R8 advance after stop");
    cyc(0, 1, 1, 0, 17'h0, "R8 advance after stop");

    // R4: interleaved burst from low bits 10
    cyc(0, 0, 1, 1, 17'h0F00E, "R2 load interleaved");
    cyc(0, 1, 1, 1, 17'h0, "R4 interleave beat1");
    cyc(0, 1, 1, 1, 17'h0, "R4 interleave beat2");
    cyc(0, 1, 1, 1, 17'h0, "R4 interleave beat3");
    cyc(0, 1, 1, 1, 17'h0, "R5 interleave wrap");

    // R9: mode change mid-burst from low bits 11
    cyc(0, 0, 1, 0, 17'h1FFFF, "R2 load top");
    cyc(0, 1, 1, 0, 17'h0, "R5 linear wrap no carry");
    cyc(1, 1, 1, 1, 17'h0, "R9 mode to interleave");
    cyc(0, 1, 1, 1, 17'h0, "R9 interleave beat2");
    cyc(1, 0, 0, 0, 17'h0, "R9 mode back to linear");

    // R2: reload during an active burst restarts
    cyc(0, 0, 1, 0, 17'h00003, "R2 reload active");
    cyc(0, 1, 1, 0, 17'h0, "R3 after reload");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule